// File: doc/BRIEF.md
# Dual-Lane Shift-Mask Accumulator Interpolator

This block holds two accumulator lanes behind a small word-addressed register bus. Each lane takes its own accumulator, or with a control bit the other lane's accumulator. It shifts the value right logically and keeps one contiguous bit field. It can treat the top bit of that field as a sign. The lane then adds its own base register to form a lane result. A combined result adds a third base register to the two field values and leaves out the lane bases.

Software reads the lane or combined results in two ways. A peek leaves all state unchanged. A pop also writes the lane results back into the accumulators at the end of the bus cycle. Pops therefore step table walks, fixed-point coordinates and address sequences by one element per bus read. Each lane has an alias address. A write to it adds to the accumulator, and a read from it returns the shifted and masked field without the base. Control bits let a lane feed the other lane's result back on a pop, bypass shift and mask for its own result, and OR two fixed high bits into the value the bus sees.

Top module: `lane_interp_unit`

## Requirements
- R1: After reset every accumulator and base register reads zero and each control register reads 0x00007C00 (shift 0, field low bit 0, field high bit 31, all mode bits clear).
- R2: The field value of a lane is its source shifted right logically by control bits 4:0, keeping only bits from control bits 9:5 up to control bits 14:10 inclusive; reading the lane alias address returns it.
- R3: With control bit 15 set, the field value is sign-extended to 32 bits from the field high bit.
- R4: A lane result read returns base plus field value; a peek changes no accumulator.
- R5: The combined result is the third base plus both lane field values, without either lane base.
- R6: A pop read at any of the three pop addresses loads each accumulator with its own lane result at the end of that cycle, so base 9 from accumulator 0 pops 9, 18, 27, ...
- R7: With control bit 17 set, a pop loads that lane's accumulator from the other lane's result.
- R8: With control bit 16 set, the other lane's accumulator is the lane's source, also for the bypass path of R9.
- R9: With control bit 18 set, the lane result is the unshifted, unmasked source plus base, while its share of the combined result stays the field value.
- R10: Control bits 20:19 are ORed into bits 29:28 of the lane result as read on the bus only; a pop stores the result without them.
- R11: Writing a lane alias address adds the written value to that accumulator.
- R12: Accumulators, bases and controls read back what was written; controls keep bits 20:0 and read zero above; writes to result addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus cycle valid this clock |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Word address: 0/1 accumulators, 2/3/4 bases, 5/6 controls, 7/8 alias, 9/10/11 peek lane0/lane1/combined, 12/13/14 pop lane0/lane1/combined |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read, zero otherwise |

## Verification
The bench builds the unit with its default 32-bit data width, so the five-bit shift and field-position controls cover every bit of the word. At this width the sign, bypass and forced-bit positions sit where the requirements place them. A behavioural model built from bit loops predicts every read, including pop write-back with and without lane crossing. The sequences cover walking a four-bit field across all eight nibbles in both signed and unsigned form, alternating crossed pops between lanes, and a two-lane fixed-point texture walk through the combined pop.

// File: rtl/lane_interp_pkg.sv
package lane_interp_pkg;
  localparam int LI_AW = 4;

  localparam logic [LI_AW-1:0] A_ACC0   = 4'd0;
  localparam logic [LI_AW-1:0] A_BASE0  = 4'd2;
  localparam logic [LI_AW-1:0] A_BASE2  = 4'd4;
  localparam logic [LI_AW-1:0] A_CTRL0  = 4'd5;
  localparam logic [LI_AW-1:0] A_ALIAS0 = 4'd7;
  localparam logic [LI_AW-1:0] A_PEEK0  = 4'd9;
  localparam logic [LI_AW-1:0] A_PEEKF  = 4'd11;
  localparam logic [LI_AW-1:0] A_POP0   = 4'd12;
  localparam logic [LI_AW-1:0] A_POPF   = 4'd14;
endpackage

// File: rtl/li_shift_mask.sv
module li_shift_mask #(
  parameter int DW  = 32,
  localparam int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  src,
  input  logic [SHW-1:0] shamt,
  input  logic [SHW-1:0] lo_bit,
  input  logic [SHW-1:0] hi_bit,
  input  logic           sgn,
  output logic [DW-1:0]  field_val
);
  logic [DW-1:0] shifted;
  logic [DW-1:0] keep_hi;
  logic [DW-1:0] keep_lo;
  logic [DW-1:0] masked;

  always_comb begin
    shifted = src >> shamt;
    keep_hi = ~(({DW{1'b1}} << hi_bit) << 1);
    keep_lo = {DW{1'b1}} << lo_bit;
    masked  = shifted & keep_hi & keep_lo;
    if (sgn && masked[hi_bit]) begin
      field_val = masked | ~keep_hi;
    end else begin
      field_val = masked;
    end
  end
endmodule

// File: rtl/li_lane_dp.sv
module li_lane_dp #(
  parameter int DW  = 32,
  localparam int SHW  = $clog2(DW),
  localparam int CW   = 3*SHW + 6,
  localparam int F_SG = 3*SHW,
  localparam int F_XI = 3*SHW + 1,
  localparam int F_RW = 3*SHW + 3,
  localparam int F_FH = 3*SHW + 4,
  localparam int FPOS = DW - 4
) (
  input  logic [DW-1:0] acc_self,
  input  logic [DW-1:0] acc_other,
  input  logic [DW-1:0] base,
  input  logic [CW-1:0] ctrl,
  output logic [DW-1:0] field_val,
  output logic [DW-1:0] res_int,
  output logic [DW-1:0] res_bus
);
  logic [DW-1:0] src;
  logic [DW-1:0] force_word;

  assign src = ctrl[F_XI] ? acc_other : acc_self;

  li_shift_mask #(.DW(DW)) u_sm (
    .src       (src),
    .shamt     (ctrl[SHW-1:0]),
    .lo_bit    (ctrl[2*SHW-1:SHW]),
    .hi_bit    (ctrl[3*SHW-1:2*SHW]),
    .sgn       (ctrl[F_SG]),
    .field_val (field_val)
  );

  always_comb begin
    res_int    = (ctrl[F_RW] ? src : field_val) + base;
    force_word = {{(DW-2){1'b0}}, ctrl[F_FH+1:F_FH]} << FPOS;
    res_bus    = res_int | force_word;
  end
endmodule

// File: rtl/li_lane_regs.sv
module li_lane_regs #(
  parameter int DW = 32,
  parameter int CW = 21,
  parameter logic [CW-1:0] CTRL_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic          wr_add,
  input  logic          wr_base,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic [DW-1:0] pop_val,
  output logic [DW-1:0] acc_q,
  output logic [DW-1:0] base_q,
  output logic [CW-1:0] ctrl_q
);
  logic [DW-1:0] acc_d;
  logic          acc_en;

  always_comb begin
    acc_en = wr_acc | wr_add | pop;
    acc_d  = acc_q;
    if (wr_acc) begin
      acc_d = wdata;
    end else if (wr_add) begin
      acc_d = acc_q + wdata;
    end else if (pop) begin
      acc_d = pop_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_base) begin
      base_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata[CW-1:0];
    end
  end

  p_add_alias_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_add && !wr_acc |=> acc_q == $past(acc_q) + $past(wdata));

  p_base_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_base |=> $stable(base_q));

  p_ctrl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/lane_interp_unit.sv
module lane_interp_unit
  import lane_interp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [LI_AW-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata
);
  localparam int NL   = 2;
  localparam int SHW  = $clog2(DW);
  localparam int CW   = 3*SHW + 6;
  localparam int F_XR = 3*SHW + 2;
  localparam logic [CW-1:0] CTRL_RST = CW'(DW-1) << (2*SHW);

  logic rs_meta_q, rs_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end
  assign rst_int_n = rs_q;

  logic                  rd_cyc, wr_cyc, pop_any;
  logic [NL-1:0][DW-1:0] acc_q, base_q, field_val, res_int, res_bus, pop_val;
  logic [NL-1:0][CW-1:0] ctrl_q;
  logic [DW-1:0]         base2_q, full_res;

  assign rd_cyc  = bus_sel && !bus_wr;
  assign wr_cyc  = bus_sel && bus_wr;
  assign pop_any = rd_cyc && (bus_addr >= A_POP0) && (bus_addr <= A_POPF);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic wr_acc, wr_add, wr_base, wr_ctrl;

    assign wr_acc  = wr_cyc && (bus_addr == LI_AW'(A_ACC0 + i));
    assign wr_add  = wr_cyc && (bus_addr == LI_AW'(A_ALIAS0 + i));
    assign wr_base = wr_cyc && (bus_addr == LI_AW'(A_BASE0 + i));
    assign wr_ctrl = wr_cyc && (bus_addr == LI_AW'(A_CTRL0 + i));

    assign pop_val[i] = ctrl_q[i][F_XR] ? res_int[NL-1-i] : res_int[i];

    li_lane_regs #(.DW(DW), .CW(CW), .CTRL_RST(CTRL_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_acc  (wr_acc),
      .wr_add  (wr_add),
      .wr_base (wr_base),
      .wr_ctrl (wr_ctrl),
      .wdata   (bus_wdata),
      .pop     (pop_any),
      .pop_val (pop_val[i]),
      .acc_q   (acc_q[i]),
      .base_q  (base_q[i]),
      .ctrl_q  (ctrl_q[i])
    );

    li_lane_dp #(.DW(DW)) u_dp (
      .acc_self  (acc_q[i]),
      .acc_other (acc_q[NL-1-i]),
      .base      (base_q[i]),
      .ctrl      (ctrl_q[i]),
      .field_val (field_val[i]),
      .res_int   (res_int[i]),
      .res_bus   (res_bus[i])
    );

    p_pop_own_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
      pop_any && !ctrl_q[i][F_XR] |=> acc_q[i] == $past(res_int[i]));

    p_pop_cross_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
      pop_any && ctrl_q[i][F_XR] |=> acc_q[i] == $past(res_int[NL-1-i]));

    p_peek_hold_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
      rd_cyc && !pop_any |=> $stable(acc_q[i]));
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      base2_q <= '0;
    end else if (wr_cyc && bus_addr == A_BASE2) begin
      base2_q <= bus_wdata;
    end
  end

  assign full_res = base2_q + field_val[0] + field_val[1];

  always_comb begin
    bus_rdata = '0;
    if (rd_cyc) begin
      case (bus_addr)
        4'd0:    bus_rdata = acc_q[0];
        4'd1:    bus_rdata = acc_q[1];
        4'd2:    bus_rdata = base_q[0];
        4'd3:    bus_rdata = base_q[1];
        4'd4:    bus_rdata = base2_q;
        4'd5:    bus_rdata = DW'(ctrl_q[0]);
        4'd6:    bus_rdata = DW'(ctrl_q[1]);
        4'd7:    bus_rdata = field_val[0];
        4'd8:    bus_rdata = field_val[1];
        4'd9,
        4'd12:   bus_rdata = res_bus[0];
        4'd10,
        4'd13:   bus_rdata = res_bus[1];
        4'd11,
        4'd14:   bus_rdata = full_res;
        default: bus_rdata = '0;
      endcase
    end
  end

  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_sel |-> bus_rdata == '0);
endmodule

// File: tb/lane_interp_unit_test.sv
module lane_interp_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_acc [2];
  logic [31:0] m_base [3];
  logic [31:0] m_ctrl [2];

  always #(CLK_P/2) clk = ~clk;

  lane_interp_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_src(int l);
    return m_ctrl[l][16] ? m_acc[1-l] : m_acc[l];
  endfunction

  function automatic logic [31:0] m_field(int l);
    logic [31:0] v, o;
    int sh, lo, hi;
    sh = int'(m_ctrl[l][4:0]);
    lo = int'(m_ctrl[l][9:5]);
    hi = int'(m_ctrl[l][14:10]);
    v = m_src(l) >> sh;
    o = '0;
    for (int b = 0; b < 32; b++) if (b >= lo && b <= hi) o[b] = v[b];
    if (m_ctrl[l][15] && hi >= lo && v[hi])
      for (int b = 0; b < 32; b++) if (b > hi) o[b] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] m_res(int l);
    return (m_ctrl[l][18] ? m_src(l) : m_field(l)) + m_base[l];
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      0: return m_acc[0];
      1: return m_acc[1];
      2: return m_base[0];
      3: return m_base[1];
      4: return m_base[2];
      5: return m_ctrl[0];
      6: return m_ctrl[1];
      7: return m_field(0);
      8: return m_field(1);
      9, 12: return m_res(0) | ({30'd0, m_ctrl[0][20:19]} << 28);
      10, 13: return m_res(1) | ({30'd0, m_ctrl[1][20:19]} << 28);
      11, 14: return m_base[2] + m_field(0) + m_field(1);
      default: return '0;
    endcase
  endfunction

  task automatic rd(input logic [3:0] a, input string tag, output logic [31:0] got);
    logic [31:0] r0, r1;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    #1 got = bus_rdata;
    chk(got, m_read(a), tag);
    if (a >= 12 && a <= 14) begin
      r0 = m_res(0); r1 = m_res(1);
      m_acc[0] = m_ctrl[0][17] ? r1 : r0;
      m_acc[1] = m_ctrl[1][17] ? r0 : r1;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    case (a)
      0: m_acc[0] = d;
      1: m_acc[1] = d;
      2: m_base[0] = d;
      3: m_base[1] = d;
      4: m_base[2] = d;
      5: m_ctrl[0] = d & 32'h001F_FFFF;
      6: m_ctrl[1] = d & 32'h001F_FFFF;
      7: m_acc[0] = m_acc[0] + d;
      8: m_acc[1] = m_acc[1] + d;
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  localparam logic [31:0] DEF = 32'h0000_7C00;

  initial begin
    logic [31:0] g, g2;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int l = 0; l < 2; l++) begin m_acc[l] = '0; m_ctrl[l] = DEF; end
    for (int l = 0; l < 3; l++) m_base[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'd5, "R1 ctrl0", g); chk(g, DEF, "R1 ctrl0 literal");
    rd(4'd6, "R1 ctrl1", g);
    rd(4'd0, "R1 acc0", g);
    rd(4'd4, "R1 base2", g);

    // R6 multiplication walk
    wr(4'd2, 32'd9);
    for (int k = 0; k < 10; k++) begin
      rd(4'd12, "R6 pop0", g); chk(g, 32'(9*(k+1)), "R6 pop0 literal");
    end

    // R4 peek leaves state
    rd(4'd9, "R4 peek0", g); rd(4'd9, "R4 peek0 again", g2);
    chk(g2, g, "R4 peek repeat");
    rd(4'd0, "R4 acc0 after peek", g); chk(g, 32'd90, "R4 acc0 literal");

    // R2 unsigned nibble walk, R3 signed nibble walk
    wr(4'd0, 32'h1234_ABCD);
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) begin
        wr(4'd5, (32'(s) << 15) | (32'(i*4+3) << 10) | (32'(i*4) << 5));
        rd(4'd7, s ? "R3 signed field" : "R2 field", g);
        if (i == 0) chk(g, s ? 32'hFFFF_FFFD : 32'h0000_000D, s ? "R3 literal" : "R2 literal");
      end
    end

    // R7 crossed pops
    wr(4'd5, DEF | (32'd1 << 17)); wr(4'd6, DEF | (32'd1 << 17));
    wr(4'd0, 32'd123); wr(4'd1, 32'd456); wr(4'd2, 32'd1); wr(4'd3, 32'd0);
    rd(4'd9, "R7 peek0", g); chk(g, 32'd124, "R7 peek0 literal");
    rd(4'd13, "R7 pop1", g); chk(g, 32'd456, "R7 pop1 literal");
    for (int k = 0; k < 4; k++) begin
      rd(4'd9, "R7 peek0", g); rd(4'd13, "R7 pop1", g);
    end
    rd(4'd1, "R7 acc1", g);

    // R5 combined result
    wr(4'd5, DEF); wr(4'd6, DEF);
    wr(4'd4, 32'd100); wr(4'd0, 32'd5); wr(4'd1, 32'd7); wr(4'd2, 32'd50); wr(4'd3, 32'd60);
    rd(4'd11, "R5 peekF", g); chk(g, 32'd112, "R5 literal");
    rd(4'd14, "R6 popF", g);
    rd(4'd0, "R6 acc0 after popF", g); chk(g, 32'd55, "R6 acc0 literal");
    rd(4'd1, "R6 acc1 after popF", g);

    // R8 cross input with bypass, R9 bypass with shift
    wr(4'd0, 32'h0000_0F00); wr(4'd1, 32'd3); wr(4'd3, 32'd2);
    wr(4'd6, DEF | (32'd1 << 16) | (32'd1 << 18));
    rd(4'd10, "R8 peek1", g); chk(g, 32'h0000_0F02, "R8 literal");
    rd(4'd8, "R8 field1", g);
    wr(4'd6, DEF); wr(4'd2, 32'd1);
    wr(4'd5, DEF | (32'd1 << 18) | 32'd4);
    rd(4'd9, "R9 peek0", g); chk(g, 32'h0000_0F01, "R9 literal");
    rd(4'd11, "R9 peekF", g); chk(g, 32'd100 + 32'h0F0 + 32'd3, "R9 full literal");

    // R10 forced high bits
    wr(4'd5, DEF | (32'd3 << 19)); wr(4'd0, 32'd5);
    rd(4'd9, "R10 peek0", g); chk(g, 32'h3000_0006, "R10 literal");
    rd(4'd12, "R10 pop0", g);
    rd(4'd0, "R10 acc0", g); chk(g, 32'd6, "R10 acc0 literal");

    // R11 add alias
    wr(4'd7, 32'd10); rd(4'd0, "R11 acc0", g); chk(g, 32'd16, "R11 literal");
    wr(4'd8, 32'hFFFF_FFFF); rd(4'd1, "R11 acc1", g);

    // R12 readback and ignored writes
    wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, "R12 ctrl1", g); chk(g, 32'h001F_FFFF, "R12 literal");
    wr(4'd3, 32'hCAFE_0001); rd(4'd3, "R12 base1", g);
    wr(4'd12, 32'h5555_5555); wr(4'd11, 32'h1);
    rd(4'd0, "R12 acc0 after result write", g); rd(4'd1, "R12 acc1 after result write", g);
    rd(4'd4, "R12 base2 after result write", g);

    // R5 R6 R9 two-lane fixed-point walk
    wr(4'd5, (32'd1 << 18) | (32'd1 << 10) | 32'd16);
    wr(4'd6, (32'd1 << 18) | (32'd3 << 10) | (32'd2 << 5) | 32'd14);
    wr(4'd4, 32'd0); wr(4'd0, 32'd0); wr(4'd1, 32'd0);
    wr(4'd2, 32'd32768); wr(4'd3, 32'd21845);
    for (int k = 0; k < 12; k++) rd(4'd14, "R5 walk popF", g);
    rd(4'd0, "R9 walk acc0", g);

    @(negedge clk); bus_sel = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule